// File: doc/BRIEF.md
# Two-Wire Bus Slave Controller with Address Masking

This block is the slave end of an I2C-style two-wire bus. It watches the clock and data lines through a synchronizer and a short glitch filter. It recognises START, repeated START and STOP, and it shifts in the address byte that follows each START. It then decides whether to acknowledge. The address byte can match an own 7-bit address or the all-zero general call. It can also match a second register, `altAddr`, which works either as another full address or as a mask that opens up a range of addresses around the own address. When hardware matching is switched off, every address byte goes to the register side, which decides the answer.

The register side sees short event pulses: address seen, data byte received, next transmit byte wanted, collision and bus error. It answers with a one-cycle `rspValid` that carries an ACK/NACK choice and, for reads, the byte to send. While an answer is pending the slave holds SCL low. It drives either line only by pulling it low.

Top module: `i2cs_slave`

## Requirements
- R1: After reset both line drives (`sclPullLow`, `sdaPullLow`) are released, and no event pulses until a START has been seen on the bus.
- R2: A START (SDA falling while SCL is high) opens an address phase. The next 8 bits are taken MSB first on SCL rising edges. `evAddr` reports them on `rxByte`, with the 7-bit address in bits 7:1 and the read flag (1 = read) in bit 0.
- R3: An address equal to `ownAddr` is acknowledged by pulling SDA low during the ninth clock. Any other unmatched address gets no event and SDA stays released (NACK).
- R4: The all-zero address is accepted only while `genCallEn` is 1.
- R5: With `altIsMask` = 0, `altAddr` is compared as a second full 7-bit address.
- R6: With `altIsMask` = 1, each set bit of `altAddr` marks an address bit that is ignored when comparing against `ownAddr`.
- R7: With `swMatch` = 1, every address byte raises `evAddr`, and the ninth bit is ACK or NACK as `rspAck` chooses.
- R8: After `evAddr`, `evRxData` or `evTxReq`, SCL is held low until `rspValid`. It is released `SETUP_CYC` cycles after the response, with SDA already set up.
- R9: In a write transfer, each data byte is received MSB first, reported with `evRxData` on `rxByte`, and acknowledged per `rspAck`.
- R10: In a read transfer, bytes from `rspData` are sent MSB first, with SDA changing only while SCL is low. A master ACK raises `evTxReq` for the next byte. A master NACK ends the transfer, and the slave then drives nothing until STOP or START.
- R11: If the slave leaves SDA released for a 1 bit but samples it low at the SCL rise, it raises `evCollision` and stops driving.
- R12: A START or STOP after at least one complete bit of a byte (not counting the ACK bit) raises `evBusErr`.
- R13: A repeated START after an acknowledged byte opens a new address phase without raising `evBusErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclPullLow | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaPullLow | output | 1 | 1 pulls SDA low |
| ownAddr | input | 7 | Primary slave address |
| altAddr | input | 7 | Second address or ignore-mask |
| altIsMask | input | 1 | 1: altAddr is a mask; 0: a second address |
| genCallEn | input | 1 | Accept the all-zero address |
| swMatch | input | 1 | Pass every address to the register side |
| rspValid | input | 1 | One-cycle response strobe |
| rspAck | input | 1 | 1 = ACK, 0 = NACK for the pending byte |
| rspData | input | 8 | Byte to transmit in a read |
| evAddr | output | 1 | Address byte accepted or flagged |
| evRxData | output | 1 | Write data byte received |
| evTxReq | output | 1 | Master acked; next transmit byte wanted |
| evCollision | output | 1 | SDA collision while transmitting |
| evBusErr | output | 1 | START/STOP inside a byte |
| rxByte | output | 8 | Last received byte, valid with evAddr/evRxData |

## Verification
Every bus-driven result lags the raw line change by the synchronizer stages, the filter length and one state register. With the defaults that is about six cycles. The bench master therefore holds each SCL phase for 20 cycles and samples SDA halfway through the high phase. Event pulses are compared on falling clock edges against a queue that the master fills before it drives each byte. The stretch is checked five cycles after each event. The release is checked `SETUP_CYC` + 2 cycles after the response strobe, when the hold has just ended.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX, ST_WAIT, ST_SETUP, ST_ACK,
    ST_TX, ST_TXACK, ST_WAITTX, ST_IGNORE
  } ctlState_e;

  typedef struct packed {
    logic clrBits;
    logic shiftIn;
    logic fallSeen;
    logic bitInc;
    logic txAdvance;
    logic loadTx;
    logic latchRx;
  } dpStrobe_t;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lvl,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0]          stableCnt;
  logic                   lvlQ, prevQ;
  logic                   syncOut;

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '1;
      lvlQ      <= 1'b1;
      prevQ     <= 1'b1;
      stableCnt <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      prevQ <= lvlQ;
      if (syncOut == lvlQ) begin
        stableCnt <= '0;
      end else if (stableCnt == CW'(FILT_LEN - 1)) begin
        lvlQ      <= syncOut;
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + CW'(1);
      end
    end
  end

  assign lvl  = lvlQ;
  assign rise = lvlQ & ~prevQ;
  assign fall = ~lvlQ & prevQ;
endmodule

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaLvl,
  input  logic [BYTE_W-1:0] rspData,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] altAddr,
  input  logic              altIsMask,
  input  logic              genCallEn,
  output logic              byteDone,
  output logic              byteOpen,
  output logic              txBit,
  output logic              rwBit,
  output logic              addrHit,
  output logic [BYTE_W-1:0] rxByte
);
  logic [BYTE_W-1:0] shiftQ;
  logic [BYTE_W-1:0] rxQ;
  logic [CNT_W-1:0]  bitCnt;
  logic              openQ;
  logic [ADDR_W-1:0] addrSeen;
  logic              hitOwn, hitAlt, hitGc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxQ    <= '0;
      bitCnt <= '0;
      openQ  <= 1'b0;
    end else begin
      if (strb.clrBits) begin
        bitCnt <= '0;
        openQ  <= 1'b0;
      end else if (strb.loadTx) begin
        shiftQ <= rspData;
        bitCnt <= '0;
        openQ  <= 1'b0;
      end else if (strb.shiftIn) begin
        shiftQ <= {shiftQ[BYTE_W-2:0], sdaLvl};
        bitCnt <= bitCnt + CNT_W'(1);
      end else if (strb.bitInc) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
      if (strb.txAdvance) shiftQ <= {shiftQ[BYTE_W-2:0], 1'b1};
      if (strb.fallSeen && bitCnt != '0) openQ <= 1'b1;
      if (strb.latchRx) rxQ <= shiftQ;
    end
  end

  assign addrSeen = shiftQ[BYTE_W-1:1];
  assign hitOwn   = (addrSeen == ownAddr);
  assign hitAlt   = altIsMask ? (((addrSeen ^ ownAddr) & ~altAddr) == '0)
                              : (addrSeen == altAddr);
  assign hitGc    = genCallEn && (addrSeen == '0);

  assign addrHit  = hitOwn | hitAlt | hitGc;
  assign rwBit    = shiftQ[0];
  assign txBit    = shiftQ[BYTE_W-1];
  assign byteDone = (bitCnt == CNT_W'(BYTE_W));
  assign byteOpen = openQ;
  assign rxByte   = rxQ;
endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
#(
  parameter int SETUP_CYC = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclLvl,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      sdaLvl,
  input  logic      sdaRise,
  input  logic      sdaFall,
  input  logic      swMatch,
  input  logic      rspValid,
  input  logic      rspAck,
  input  logic      byteDone,
  input  logic      byteOpen,
  input  logic      txBit,
  input  logic      rwBit,
  input  logic      addrHit,
  output dpStrobe_t strb,
  output logic      sclPullLow,
  output logic      sdaPullLow,
  output logic      evAddr,
  output logic      evRxData,
  output logic      evTxReq,
  output logic      evCollision,
  output logic      evBusErr
);
  localparam int HCW = $clog2(SETUP_CYC + 1);

  ctlState_e state, nxt;
  logic isAddr, isAddrN, readXfer, readN, ackReg, ackN;
  logic masterAck, mAckN, toTx, toTxN;
  logic [HCW-1:0] holdCnt, holdN;
  logic eAddr, eRx, eTx, eColl, eBus;
  logic startCond, stopCond, inByte;

  assign startCond = sdaFall & sclLvl;
  assign stopCond  = sdaRise & sclLvl;
  assign inByte    = (state == ST_RX) || (state == ST_TX);

  always_comb begin
    nxt = state; strb = '0;
    isAddrN = isAddr; readN = readXfer; ackN = ackReg;
    mAckN = masterAck; toTxN = toTx; holdN = holdCnt;
    eAddr = 1'b0; eRx = 1'b0; eTx = 1'b0; eColl = 1'b0; eBus = 1'b0;
    if (startCond) begin
      eBus = inByte && byteOpen;
      nxt = ST_RX; isAddrN = 1'b1; strb.clrBits = 1'b1;
    end else if (stopCond) begin
      eBus = inByte && byteOpen;
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
          end else if (sclFall) begin
            strb.fallSeen = 1'b1;
            if (byteDone) begin
              strb.latchRx = 1'b1;
              if (!isAddr) begin
                eRx = 1'b1; nxt = ST_WAIT;
              end else if (swMatch || addrHit) begin
                eAddr = 1'b1; readN = rwBit; nxt = ST_WAIT;
              end else begin
                nxt = ST_IGNORE;
              end
            end
          end
        end
        ST_WAIT: if (rspValid) begin
          ackN = rspAck; toTxN = 1'b0; holdN = '0; nxt = ST_SETUP;
          strb.loadTx = isAddr && readXfer && rspAck;
        end
        ST_SETUP: begin
          if (holdCnt == HCW'(SETUP_CYC - 1)) nxt = toTx ? ST_TX : ST_ACK;
          else holdN = holdCnt + HCW'(1);
        end
        ST_ACK: if (sclFall) begin
          isAddrN = 1'b0;
          if (!ackReg) nxt = ST_IGNORE;
          else if (readXfer) nxt = ST_TX;
          else begin nxt = ST_RX; strb.clrBits = 1'b1; end
        end
        ST_TX: begin
          if (sclRise) begin
            if (txBit && !sdaLvl) begin eColl = 1'b1; nxt = ST_IGNORE; end
            else strb.bitInc = 1'b1;
          end else if (sclFall) begin
            if (byteDone) nxt = ST_TXACK;
            else begin strb.txAdvance = 1'b1; strb.fallSeen = 1'b1; end
          end
        end
        ST_TXACK: begin
          if (sclRise) mAckN = !sdaLvl;
          else if (sclFall) begin
            if (masterAck) begin eTx = 1'b1; nxt = ST_WAITTX; end
            else nxt = ST_IGNORE;
          end
        end
        ST_WAITTX: if (rspValid) begin
          strb.loadTx = 1'b1; toTxN = 1'b1; holdN = '0; nxt = ST_SETUP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; isAddr <= 1'b0; readXfer <= 1'b0; ackReg <= 1'b0;
      masterAck <= 1'b0; toTx <= 1'b0; holdCnt <= '0;
      evAddr <= 1'b0; evRxData <= 1'b0; evTxReq <= 1'b0;
      evCollision <= 1'b0; evBusErr <= 1'b0;
    end else begin
      state <= nxt; isAddr <= isAddrN; readXfer <= readN; ackReg <= ackN;
      masterAck <= mAckN; toTx <= toTxN; holdCnt <= holdN;
      evAddr <= eAddr; evRxData <= eRx; evTxReq <= eTx;
      evCollision <= eColl; evBusErr <= eBus;
    end
  end

  assign sclPullLow = (state == ST_WAIT) || (state == ST_WAITTX) || (state == ST_SETUP);

  always_comb begin
    if ((state == ST_SETUP && !toTx) || state == ST_ACK) sdaPullLow = ackReg;
    else if ((state == ST_SETUP && toTx) || state == ST_TX) sdaPullLow = !txBit;
    else sdaPullLow = 1'b0;
  end
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int SETUP_CYC   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] altAddr,
  input  logic              altIsMask,
  input  logic              genCallEn,
  input  logic              swMatch,
  input  logic              rspValid,
  input  logic              rspAck,
  input  logic [BYTE_W-1:0] rspData,
  output logic              evAddr,
  output logic              evRxData,
  output logic              evTxReq,
  output logic              evCollision,
  output logic              evBusErr,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] rawBus, lineLvl, lineRise, lineFall;
  dpStrobe_t strb;
  logic byteDone, byteOpen, txBit, rwBit, addrHit;

  assign rawBus = {sdaIn, sclIn};

  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
    i2cs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawBus[gi]),
      .lvl(lineLvl[gi]), .rise(lineRise[gi]), .fall(lineFall[gi])
    );
  end

  i2cs_control #(.SETUP_CYC(SETUP_CYC)) u_ctl (
    .clk(clk), .rstN(rstN),
    .sclLvl(lineLvl[0]), .sclRise(lineRise[0]), .sclFall(lineFall[0]),
    .sdaLvl(lineLvl[1]), .sdaRise(lineRise[1]), .sdaFall(lineFall[1]),
    .swMatch(swMatch), .rspValid(rspValid), .rspAck(rspAck),
    .byteDone(byteDone), .byteOpen(byteOpen), .txBit(txBit),
    .rwBit(rwBit), .addrHit(addrHit), .strb(strb),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
    .evAddr(evAddr), .evRxData(evRxData), .evTxReq(evTxReq),
    .evCollision(evCollision), .evBusErr(evBusErr)
  );

  i2cs_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaLvl(lineLvl[1]),
    .rspData(rspData), .ownAddr(ownAddr), .altAddr(altAddr),
    .altIsMask(altIsMask), .genCallEn(genCallEn),
    .byteDone(byteDone), .byteOpen(byteOpen), .txBit(txBit),
    .rwBit(rwBit), .addrHit(addrHit), .rxByte(rxByte)
  );
endmodule

// File: rtl/i2cs_slave_chk.sv
module i2cs_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sclPullLow,
  input logic sdaPullLow,
  input logic rspValid,
  input logic evAddr,
  input logic evRxData,
  input logic evTxReq,
  input logic evCollision,
  input logic evBusErr
);
  logic waitQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitQ <= 1'b0;
    else if (evAddr || evRxData || evTxReq) waitQ <= 1'b1;
    else if (rspValid) waitQ <= 1'b0;
  end

  a_r1_reset_released: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!sclPullLow && !sdaPullLow));
  a_r1_single_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evAddr, evRxData, evTxReq, evCollision, evBusErr}));
  a_r8_stretch_on_event: assert property (@(posedge clk) disable iff (!rstN)
    (evAddr || evRxData || evTxReq) |-> sclPullLow);
  a_r8_hold_until_rsp: assert property (@(posedge clk) disable iff (!rstN)
    (waitQ && !rspValid) |=> sclPullLow);
  a_r8_txreq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    evTxReq |=> !evTxReq);
  a_r11_release_on_coll: assert property (@(posedge clk) disable iff (!rstN)
    evCollision |-> !sdaPullLow);
  a_r12_no_stretch_on_err: assert property (@(posedge clk) disable iff (!rstN)
    evBusErr |-> !sclPullLow);
endmodule

bind i2cs_slave i2cs_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
  .rspValid(rspValid), .evAddr(evAddr), .evRxData(evRxData),
  .evTxReq(evTxReq), .evCollision(evCollision), .evBusErr(evBusErr)
);

// File: tb/tb_i2cs_slave.sv
`timescale 1ns/1ps
module tb_i2cs_slave;
  localparam int Q = 20;
  localparam int SETUP_CYC = 4;
  localparam int RESP_DLY = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclLine, sdaLine, sclPullLow, sdaPullLow;
  logic [6:0] ownAddr = 7'h3A, altAddr = 7'h7F;
  logic altIsMask = 1'b0, genCallEn = 1'b0, swMatch = 1'b0;
  logic rspValid = 1'b0, rspAck = 1'b0;
  logic [7:0] rspData = 8'h00;
  logic evAddr, evRxData, evTxReq, evCollision, evBusErr;
  logic [7:0] rxByte;
  logic respAck = 1'b1;
  logic [7:0] txQ[$];
  int expKind[$];
  int expData[$];
  string expTag[$];
  int checkCount = 0, failCount = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sclLine = mScl & ~sclPullLow;
  assign sdaLine = mSda & ~sdaPullLow;

  i2cs_slave #(.SETUP_CYC(SETUP_CYC)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
    .ownAddr(ownAddr), .altAddr(altAddr), .altIsMask(altIsMask),
    .genCallEn(genCallEn), .swMatch(swMatch), .rspValid(rspValid),
    .rspAck(rspAck), .rspData(rspData), .evAddr(evAddr),
    .evRxData(evRxData), .evTxReq(evTxReq), .evCollision(evCollision),
    .evBusErr(evBusErr), .rxByte(rxByte)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // kinds: 0 addr, 1 rx data, 2 tx request, 3 collision, 4 bus error
  task automatic expectEv(input int kind, input int data, input string tag);
    expKind.push_back(kind); expData.push_back(data); expTag.push_back(tag);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclRelease();
    mScl = 1'b1;
    while (!sclLine) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitCyc(Q); sclRelease(); waitCyc(Q);
    mSda = 1'b0; waitCyc(Q); mScl = 1'b0; waitCyc(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitCyc(Q); sclRelease(); waitCyc(Q);
    mSda = 1'b1; waitCyc(Q);
  endtask

  task automatic putBit(input logic b);
    mSda = b; waitCyc(Q); sclRelease(); waitCyc(2 * Q);
    mScl = 1'b0; waitCyc(Q);
  endtask

  task automatic getBit(output logic b);
    mSda = 1'b1; waitCyc(Q); sclRelease(); waitCyc(Q);
    b = sdaLine; waitCyc(Q); mScl = 1'b0; waitCyc(Q);
  endtask

  task automatic putByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    acked = !b;
  endtask

  task automatic getByte(output logic [7:0] v, input logic ackIt);
    logic b;
    for (int i = 7; i >= 0; i--) begin getBit(b); v[i] = b; end
    putBit(!ackIt);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      logic [4:0] evVec;
      evVec = {evBusErr, evCollision, evTxReq, evRxData, evAddr};
      for (int k = 0; k < 5; k++) begin
        if (evVec[k]) begin
          if (expKind.size() == 0) chk("R1 unexpected event", k, 99);
          else begin
            int ek, ed; string et;
            ek = expKind.pop_front(); ed = expData.pop_front(); et = expTag.pop_front();
            chk(et, k, ek);
            if (k < 2) chk(et, rxByte, ed);
          end
        end
      end
    end
  end

  // register-side responder
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && (evAddr || evRxData || evTxReq)) begin
        logic needTx;
        needTx = evTxReq || (evAddr && rxByte[0]);
        waitCyc(5);
        chk("R8 SCL held while waiting", sclPullLow, 1);
        waitCyc(RESP_DLY);
        rspAck = respAck;
        rspData = (needTx && txQ.size() > 0) ? txQ.pop_front() : 8'h00;
        rspValid = 1'b1;
        @(negedge clk);
        rspValid = 1'b0;
        waitCyc(SETUP_CYC + 2);
        chk("R8 SCL released after response", sclPullLow, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    waitCyc(5);
    chk("R1 SCL released in reset", sclPullLow, 0);
    chk("R1 SDA released in reset", sdaPullLow, 0);
    rstN = 1'b1;
    waitCyc(20);
    chk("R1 SCL released after reset", sclPullLow, 0);
    chk("R1 SDA released after reset", sdaPullLow, 0);

    // R2 R3 R9: write two bytes to own address
    expectEv(0, 8'h74, "R2 address byte");
    expectEv(1, 8'hA5, "R9 first data byte");
    expectEv(1, 8'h3C, "R9 second data byte");
    busStart();
    putByte(8'h74, ack); chk("R3 own address acked", ack, 1);
    putByte(8'hA5, ack); chk("R9 data acked", ack, 1);
    putByte(8'h3C, ack); chk("R9 data acked", ack, 1);
    busStop(); waitCyc(Q);

    // R3: unmatched address
    busStart();
    putByte(8'h76, ack); chk("R3 foreign address not acked", ack, 0);
    busStop(); waitCyc(Q);

    // R5: dual address
    altAddr = 7'h21;
    expectEv(0, 8'h42, "R5 second address");
    busStart(); putByte(8'h42, ack); chk("R5 second address acked", ack, 1);
    busStop(); waitCyc(Q);
    busStart(); putByte(8'h40, ack); chk("R5 neighbour not acked", ack, 0);
    busStop(); waitCyc(Q);

    // R6: mask mode
    ownAddr = 7'h50; altAddr = 7'h03; altIsMask = 1'b1;
    expectEv(0, 8'hA4, "R6 masked range address");
    busStart(); putByte(8'hA4, ack); chk("R6 address in range acked", ack, 1);
    busStop(); waitCyc(Q);
    busStart(); putByte(8'hAC, ack); chk("R6 address out of range not acked", ack, 0);
    busStop(); waitCyc(Q);
    ownAddr = 7'h3A; altAddr = 7'h7F; altIsMask = 1'b0;

    // R4: general call
    busStart(); putByte(8'h00, ack); chk("R4 general call off not acked", ack, 0);
    busStop(); waitCyc(Q);
    genCallEn = 1'b1;
    expectEv(0, 8'h00, "R4 general call address");
    expectEv(1, 8'h06, "R4 general call data");
    busStart(); putByte(8'h00, ack); chk("R4 general call acked", ack, 1);
    putByte(8'h06, ack); chk("R4 general call data acked", ack, 1);
    busStop(); waitCyc(Q);
    genCallEn = 1'b0;

    // R7: software matching
    swMatch = 1'b1; respAck = 1'b0;
    expectEv(0, 8'h22, "R7 flagged address");
    busStart(); putByte(8'h22, ack); chk("R7 software NACK", ack, 0);
    busStop(); waitCyc(Q);
    respAck = 1'b1;
    expectEv(0, 8'h24, "R7 flagged address");
    busStart(); putByte(8'h24, ack); chk("R7 software ACK", ack, 1);
    busStop(); waitCyc(Q);
    swMatch = 1'b0;

    // R10 R13: write pointer, repeated START, read two bytes
    txQ.push_back(8'hC3); txQ.push_back(8'h5A);
    expectEv(0, 8'h74, "R13 write address");
    expectEv(1, 8'h10, "R13 pointer byte");
    expectEv(0, 8'h75, "R13 read address after repeated START");
    expectEv(2, 0, "R10 next byte request");
    busStart(); putByte(8'h74, ack); putByte(8'h10, ack);
    busStart();
    putByte(8'h75, ack); chk("R13 read address acked", ack, 1);
    getByte(rd, 1'b1); chk("R10 first read byte", rd, 8'hC3);
    getByte(rd, 1'b0); chk("R10 second read byte", rd, 8'h5A);
    waitCyc(Q);
    chk("R10 SDA released after NACK", sdaPullLow, 0);
    chk("R10 SCL released after NACK", sclPullLow, 0);
    busStop(); waitCyc(Q);

    // R11: collision while transmitting a 1
    txQ.push_back(8'hFF);
    expectEv(0, 8'h75, "R11 read address");
    expectEv(3, 0, "R11 collision");
    busStart(); putByte(8'h75, ack);
    putBit(1'b0);
    chk("R11 SDA released after collision", sdaPullLow, 0);
    busStop(); waitCyc(Q);

    // R12: START and STOP inside a byte
    expectEv(4, 0, "R12 START mid-byte");
    expectEv(0, 8'h74, "R12 address after restart");
    busStart(); putBit(1'b1); putBit(1'b0); putBit(1'b1);
    busStart();
    putByte(8'h74, ack); chk("R12 address after restart acked", ack, 1);
    busStop(); waitCyc(Q);
    expectEv(4, 0, "R12 STOP mid-byte");
    busStart(); putBit(1'b0); putBit(1'b1);
    busStop(); waitCyc(4 * Q);

    chk("R2 all expected events seen", expKind.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule